// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a system watchdog that software programs through a small register port. Once it is released from halt, a counter steps down by one on every tick-enable pulse from an external prescaler, where each tick stands for 0.6 seconds. If the counter runs out, the block raises a first-timeout flag and reloads itself. If software does not clear that flag and refresh the counter, a second run-out asserts a one-cycle system reset request. An input strap can suppress the reset request. The status bits still record what happened.

Two generations are selected by a parameter. In the narrow generation the initial value is a 6-bit field in a byte register, and software must clear the first-timeout flag explicitly. In the wide generation the initial value is a 10-bit field in a word register, and a refresh write also clears the first-timeout flag. Both generations refuse initial values below four. Software can detect the refusal by reading the register back.

Top module: `twostage_wdog`

## Requirements
- R1: After synchronous reset the control register at offset 0x08 reads 0x0800 (halted), the initial-value register reads 4, the count at offset 0x00 reads 4, both status registers read 0, and rst_req and tmo_irq are 0.
- R2: While running, each tick lowers the count by one. A read presents the value of the addressed register on rdata one cycle after the address is applied. Offset 0x00 returns the current count, zero-extended from the active field width.
- R3: Bit 11 of the control register at offset 0x08 halts the counter when it is 1 and lets it run when it is 0. The register reads back the full word as written.
- R4: Any write to offset 0x00 loads the counter with the stored initial value, whether or not the counter is halted. This load takes precedence over a tick in the same cycle.
- R5: A tick that arrives while the counter is running and reads 0 is an expiry. The first expiry sets bit 3 of the status register at offset 0x04, raises tmo_irq and reloads the counter, so an initial value N gives N+1 ticks to expiry.
- R6: An expiry while bit 3 of offset 0x04 is already set is a second timeout. It sets bit 1 of the status register at offset 0x06 and drives rst_req high for exactly one cycle, in the cycle after the expiring tick.
- R7: Writing 1 to bit 3 of offset 0x04, or to bits 1 or 2 of offset 0x06, clears that bit. Writing 0 leaves it unchanged. A setting event in the same cycle takes precedence over the clear.
- R8: In the narrow generation the initial value is bits [5:0] of the byte register at offset 0x01. In the wide generation it is bits [9:0] of the word register at offset 0x12. All other bits of that register store and read back exactly as written.
- R9: A write that carries an initial-value field of 0 to 3 leaves the stored field unchanged. The other bits of the register still take the written value.
- R10: While no_reboot is 1, a second timeout does not assert rst_req. It still sets bit 1 of offset 0x06, and it also sets the boot flag in bit 2 of offset 0x06.
- R11: In the wide generation a write to offset 0x00 also clears bit 3 of offset 0x04. In the narrow generation it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle countdown enable from the prescaler |
| addr | input | ADDR_W | Register offset for reads and writes |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe for the addressed register |
| no_reboot | input | 1 | Strap that suppresses the reset request |
| rdata | output | DATA_W | Registered read data for the previous cycle's address |
| rst_req | output | 1 | One-cycle system reset request |
| tmo_irq | output | 1 | First-timeout flag, a copy of status bit 3 |

## Verification
A wrong count shows up on the very next read of offset 0x00. It also shifts the cycle in which tmo_irq rises, and the per-cycle model comparison catches that shift on the first clock where the two differ. A stale or wrongly cleared first-timeout flag changes whether the next expiry produces a reset pulse or only a first timeout. That difference appears on rst_req one cycle after the expiring tick. A wrong stored initial value shows up one cycle after the read-back that follows the write, and again in the length of every later countdown.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;
  // register offsets; the narrow and wide initial-value homes differ by generation
  localparam logic [4:0] OFF_RELOAD = 5'h00;
  localparam logic [4:0] OFF_INIT_N = 5'h01;
  localparam logic [4:0] OFF_STS_A  = 5'h04;
  localparam logic [4:0] OFF_STS_B  = 5'h06;
  localparam logic [4:0] OFF_CTRL   = 5'h08;
  localparam logic [4:0] OFF_INIT_W = 5'h12;

  localparam int HALT_POS = 11;
  localparam int TMO_POS  = 3;
  localparam int SEC_POS  = 1;
  localparam int BOOT_POS = 2;
  localparam int MIN_INIT = 4;
  localparam int BYTE_W   = 8;

  typedef struct packed {
    logic tmo;
    logic sec;
    logic boot;
  } clr_t;
endpackage

// File: rtl/twostage_wdog_count.sv
module twostage_wdog_count
  import twostage_wdog_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          halt,
  input  logic          load,
  input  logic [CW-1:0] init_val,
  output logic [CW-1:0] cnt,
  output logic          expire
);

  assign expire = tick && !halt && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(MIN_INIT);
    end else if (load || expire) begin
      cnt <= init_val;
    end else if (tick && !halt) begin
      cnt <= cnt - CW'(1);
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt && !load) |=> $stable(cnt));                                   // R3
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(init_val)));                                  // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !halt && !load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1))); // R2

endmodule

// File: rtl/twostage_wdog_stage.sv
module twostage_wdog_stage
  import twostage_wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic no_reboot,
  input  clr_t clr,
  output logic tmo,
  output logic sec,
  output logic boot,
  output logic rst_req
);

  logic second;
  assign second = expire && tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo     <= 1'b0;
      sec     <= 1'b0;
      boot    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= second && !no_reboot;
      if (expire)        tmo <= 1'b1;
      else if (clr.tmo)  tmo <= 1'b0;
      if (second)        sec <= 1'b1;
      else if (clr.sec)  sec <= 1'b0;
      if (second && no_reboot) boot <= 1'b1;
      else if (clr.boot)       boot <= 1'b0;
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);                                               // R6
  AST_RST_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (tmo && sec));                                           // R6
  AST_NOREBOOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    no_reboot |=> !rst_req);                                             // R10
  AST_FIRST_SETS: assert property (@(posedge clk) disable iff (rst)
    expire |=> tmo);                                                     // R5
  AST_W1C_TMO: assert property (@(posedge clk) disable iff (rst)
    (clr.tmo && !expire) |=> !tmo);                                      // R7

endmodule

// File: rtl/twostage_wdog_regs.sv
module twostage_wdog_regs
  import twostage_wdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CW     = 6,
  parameter bit WIDE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic [CW-1:0]     cnt,
  input  logic              tmo,
  input  logic              sec,
  input  logic              boot,
  output logic              halt,
  output logic [CW-1:0]     init_val,
  output logic              load,
  output clr_t              clr,
  output logic [DATA_W-1:0] rdata
);

  localparam int IREG_W = WIDE ? DATA_W : BYTE_W;
  localparam logic [ADDR_W-1:0] A_INIT   = WIDE ? ADDR_W'(OFF_INIT_W) : ADDR_W'(OFF_INIT_N);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_STS_A  = ADDR_W'(OFF_STS_A);
  localparam logic [ADDR_W-1:0] A_STS_B  = ADDR_W'(OFF_STS_B);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

  logic [DATA_W-1:0] ctrl_q;
  logic [IREG_W-1:0] init_q;
  logic [IREG_W-1:0] init_wr;
  logic              init_ok;
  logic [DATA_W-1:0] rd_next;

  // illegal field values keep the old field; the surrounding bits still update
  assign init_ok = wdata[CW-1:0] >= CW'(MIN_INIT);
  assign init_wr = init_ok ? wdata[IREG_W-1:0] : {wdata[IREG_W-1:CW], init_q[CW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= DATA_W'(1) << HALT_POS;
      init_q <= IREG_W'(MIN_INIT);
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_INIT) init_q <= init_wr;
    end
  end

  assign halt     = ctrl_q[HALT_POS];
  assign init_val = init_q[CW-1:0];
  assign load     = wr_en && (addr == A_RELOAD);

  always_comb begin
    clr.tmo  = (wr_en && addr == A_STS_A && wdata[TMO_POS]) || (WIDE && load);
    clr.sec  = wr_en && addr == A_STS_B && wdata[SEC_POS];
    clr.boot = wr_en && addr == A_STS_B && wdata[BOOT_POS];
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      A_RELOAD: rd_next = DATA_W'(cnt);
      A_INIT:   rd_next = DATA_W'(init_q);
      A_STS_A:  rd_next[TMO_POS] = tmo;
      A_STS_B: begin
        rd_next[SEC_POS]  = sec;
        rd_next[BOOT_POS] = boot;
      end
      A_CTRL:   rd_next = ctrl_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  AST_INIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    init_q[CW-1:0] >= CW'(MIN_INIT));                                    // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_CTRL) |=> $stable(ctrl_q));                     // R3

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import twostage_wdog_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 6,
  parameter int WIDE_W   = 10,
  parameter bit WIDE     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              no_reboot,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              tmo_irq
);

  localparam int CW = WIDE ? WIDE_W : NARROW_W;

  logic [CW-1:0] cnt;
  logic [CW-1:0] init_val;
  logic          halt;
  logic          load;
  logic          expire;
  logic          tmo;
  logic          sec;
  logic          boot;
  clr_t          clr;

  twostage_wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW), .WIDE(WIDE)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .cnt(cnt), .tmo(tmo), .sec(sec), .boot(boot),
    .halt(halt), .init_val(init_val), .load(load), .clr(clr), .rdata(rdata)
  );

  twostage_wdog_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .load(load),
    .init_val(init_val), .cnt(cnt), .expire(expire)
  );

  twostage_wdog_stage u_stage (
    .clk(clk), .rst(rst), .expire(expire), .no_reboot(no_reboot), .clr(clr),
    .tmo(tmo), .sec(sec), .boot(boot), .rst_req(rst_req)
  );

  assign tmo_irq = tmo;

endmodule

// File: tb/twostage_wdog_bench.sv
`timescale 1ns/1ps
module twostage_wdog_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic live = 1'b0;
  logic b_nr = 1'b0;
  logic [4:0]  b_addr  [2];
  logic [15:0] b_wdata [2];
  logic        b_wr    [2];
  logic        b_tick  [2];
  logic [15:0] d_rdata [2];
  logic        d_rst   [2];
  logic        d_irq   [2];
  int checks = 0;
  int fails  = 0;

  int m_cnt[2], m_ctrl[2], m_init[2], m_tmo[2], m_sec[2], m_boot[2], m_rst[2], m_rd[2];

  always #2.5 clk = ~clk;

  twostage_wdog #(.WIDE(1'b0)) u_twostage_wdog (
    .clk(clk), .rst(rst), .tick(b_tick[0]), .addr(b_addr[0]), .wdata(b_wdata[0]),
    .wr_en(b_wr[0]), .no_reboot(b_nr), .rdata(d_rdata[0]), .rst_req(d_rst[0]), .tmo_irq(d_irq[0]));

  twostage_wdog #(.WIDE(1'b1)) u_twostage_wdog_wide (
    .clk(clk), .rst(rst), .tick(b_tick[1]), .addr(b_addr[1]), .wdata(b_wdata[1]),
    .wr_en(b_wr[1]), .no_reboot(b_nr), .rdata(d_rdata[1]), .rst_req(d_rst[1]), .tmo_irq(d_irq[1]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int mread(input int i, input int a);
    case (a)
      'h00: return m_cnt[i];
      'h01: return (i == 0) ? m_init[i] : 0;
      'h12: return (i == 1) ? m_init[i] : 0;
      'h04: return m_tmo[i] << 3;
      'h06: return (m_sec[i] << 1) | (m_boot[i] << 2);
      'h08: return m_ctrl[i];
      default: return 0;
    endcase
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int a, d, rd, oldinit, nv, fmask;
    bit w, t, ld, hlt, ex, second, ctmo, csec, cboot;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_cnt[i] = 4; m_ctrl[i] = 'h800; m_init[i] = 4;
        m_tmo[i] = 0; m_sec[i] = 0; m_boot[i] = 0; m_rst[i] = 0; m_rd[i] = 0;
      end else begin
        a = int'(b_addr[i]); d = int'(b_wdata[i]); w = b_wr[i]; t = b_tick[i];
        fmask = (i == 0) ? 'h3f : 'h3ff;
        rd = mread(i, a);
        oldinit = m_init[i];
        ld = w && a == 0;
        hlt = ((m_ctrl[i] >> 11) & 1) == 1;
        ex = t && !hlt && !ld && m_cnt[i] == 0;
        second = ex && m_tmo[i] == 1;
        ctmo = (w && a == 4 && d[3]) || (i == 1 && ld);
        csec = w && a == 6 && d[1];
        cboot = w && a == 6 && d[2];
        if (w && a == 8) m_ctrl[i] = d;
        if (w && i == 0 && a == 1) begin
          nv = d & 'hff;
          m_init[i] = ((nv & 'h3f) >= 4) ? nv : ((nv & 'hc0) | (oldinit & 'h3f));
        end
        if (w && i == 1 && a == 'h12) begin
          nv = d & 'hffff;
          m_init[i] = ((nv & 'h3ff) >= 4) ? nv : ((nv & 'hfc00) | (oldinit & 'h3ff));
        end
        if (ld || ex) m_cnt[i] = oldinit & fmask;
        else if (t && !hlt) m_cnt[i] = m_cnt[i] - 1;
        m_rst[i] = (second && !b_nr) ? 1 : 0;
        if (second) m_sec[i] = 1; else if (csec) m_sec[i] = 0;
        if (second && b_nr) m_boot[i] = 1; else if (cboot) m_boot[i] = 0;
        if (ex) m_tmo[i] = 1; else if (ctmo) m_tmo[i] = 0;
        m_rd[i] = rd;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && live) begin
      for (int i = 0; i < 2; i++) begin
        chk(int'(d_rdata[i]) == m_rd[i], "R2 per-cycle rdata", int'(d_rdata[i]), m_rd[i]);
        chk(int'(d_rst[i]) == m_rst[i], "R6 per-cycle rst_req", int'(d_rst[i]), m_rst[i]);
        chk(int'(d_irq[i]) == m_tmo[i], "R5 per-cycle tmo_irq", int'(d_irq[i]), m_tmo[i]);
      end
    end
  end

  task automatic rd_chk(input int i, input int a, input int exp, input string tag);
    b_addr[i] = 5'(a);
    @(posedge clk); @(negedge clk);
    chk(int'(d_rdata[i]) == exp, tag, int'(d_rdata[i]), exp);
  endtask

  task automatic wr(input int i, input int a, input int d);
    b_addr[i] = 5'(a); b_wdata[i] = 16'(d); b_wr[i] = 1'b1;
    @(posedge clk); @(negedge clk);
    b_wr[i] = 1'b0;
  endtask

  task automatic tk(input int i, input int n);
    for (int k = 0; k < n; k++) begin
      b_tick[i] = 1'b1;
      @(posedge clk); @(negedge clk);
      b_tick[i] = 1'b0;
    end
  endtask

  task automatic run_mode(input int i);
    int ia;
    ia = (i == 0) ? 'h01 : 'h12;
    chk(d_rst[i] == 1'b0 && d_irq[i] == 1'b0, "R1 outputs idle", int'(d_rst[i]), 0);
    rd_chk(i, 'h08, 'h800, "R1 control halted");
    rd_chk(i, 'h04, 0, "R1 status A clear");
    rd_chk(i, 'h06, 0, "R1 status B clear");
    rd_chk(i, ia, 4, "R1 initial value");
    rd_chk(i, 'h00, 4, "R1 count");
    if (i == 0) begin
      wr(i, ia, 'hC5);   rd_chk(i, ia, 'hC5, "R8 narrow field and spare bits");
      wr(i, ia, 'h02);   rd_chk(i, ia, 'h05, "R9 narrow illegal value rejected");
    end else begin
      wr(i, ia, 'hA405); rd_chk(i, ia, 'hA405, "R8 wide field and spare bits");
      wr(i, ia, 'h1003); rd_chk(i, ia, 'h1005, "R9 wide illegal value rejected");
    end
    wr(i, 'h00, 0);      rd_chk(i, 'h00, 5, "R4 reload while halted");
    tk(i, 3);            rd_chk(i, 'h00, 5, "R3 halted count frozen");
    wr(i, 'h08, 0);      rd_chk(i, 'h08, 0, "R3 control read-back");
    tk(i, 2);            rd_chk(i, 'h00, 3, "R2 count after two ticks");
    b_addr[i] = 5'h00; b_wr[i] = 1'b1; b_tick[i] = 1'b1;
    @(posedge clk); @(negedge clk);
    b_wr[i] = 1'b0; b_tick[i] = 1'b0;
    rd_chk(i, 'h00, 5, "R4 reload beats tick");
    tk(i, 6);
    chk(d_irq[i] == 1'b1, "R5 tmo_irq after first expiry", int'(d_irq[i]), 1);
    rd_chk(i, 'h04, 8, "R5 status A bit 3 set");
    rd_chk(i, 'h00, 5, "R5 counter reloaded");
    wr(i, 'h04, 0);      rd_chk(i, 'h04, 8, "R7 writing zero keeps status");
    wr(i, 'h00, 0);
    if (i == 0) begin
      rd_chk(i, 'h04, 8, "R11 narrow refresh keeps status");
    end else begin
      rd_chk(i, 'h04, 0, "R11 wide refresh clears status");
      tk(i, 6);
      rd_chk(i, 'h04, 8, "R5 wide first expiry again");
    end
    tk(i, 5);
    chk(d_rst[i] == 1'b0, "R6 no reset before second expiry", int'(d_rst[i]), 0);
    tk(i, 1);
    chk(d_rst[i] == 1'b1, "R6 reset on second expiry", int'(d_rst[i]), 1);
    @(posedge clk); @(negedge clk);
    chk(d_rst[i] == 1'b0, "R6 reset lasts one cycle", int'(d_rst[i]), 0);
    rd_chk(i, 'h06, 2, "R6 second-timeout bit");
    wr(i, 'h06, 2);      rd_chk(i, 'h06, 0, "R7 clear second-timeout bit");
    wr(i, 'h04, 8);      rd_chk(i, 'h04, 0, "R7 clear first-timeout bit");
    b_nr = 1'b1;
    wr(i, 'h00, 0);
    tk(i, 6);
    tk(i, 6);
    chk(d_rst[i] == 1'b0, "R10 reset suppressed", int'(d_rst[i]), 0);
    rd_chk(i, 'h06, 6, "R10 second-timeout and boot bits");
    rd_chk(i, 'h04, 8, "R10 first-timeout still set");
    b_nr = 1'b0;
    wr(i, 'h06, 6);      rd_chk(i, 'h06, 0, "R7 clear boot and second bits");
    wr(i, 'h08, 'h800);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      b_addr[i] = '0; b_wdata[i] = '0; b_wr[i] = 1'b0; b_tick[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    run_mode(0);
    run_mode(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    report();
  end
endmodule